// File: doc/BRIEF.md
# Synchronous Burst Address Generator

This block forms the internal address that a synchronous burst SRAM uses on each cycle. On a clock edge where one of two start strobes is accepted, it takes in the external address bus. On later edges it can step the two least significant address bits to walk through a four-beat burst. It steps only on cycles where the advance input is high. A new external address can be taken on any cycle at no cost, so the host may skip bursts entirely and present a fresh address every cycle.

There are two start strobes, one driven by the processor and one by the cache controller. Each has its own gating by the two chip enables. A registered select flag shows whether the generator currently points at a live access. A mode pin chooses the wrap sequence inside the four-beat group:

- Linear order: beat k is the start offset plus k, modulo 4.
- Interleaved order: beat k is the start offset XOR k.

The upper address bits never move during a burst.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, addr_o is 0 and sel_o is 0.
- R2: At a clock edge with cpu_strobe_i=1, ce_i=1 and ce2_i=1, addr_o takes the value of addr_i and sel_o becomes 1. The beat count restarts at 0.
- R3: At an edge with ce_i=0, cpu_strobe_i has no effect. With ctl_strobe_i=0 and adv_i=0 as well, addr_o and sel_o keep their values.
- R4: An edge with ctl_strobe_i=1 and no accepted processor strobe has one of two effects. If ce_i=1 and ce2_i=1, it loads addr_i and sets sel_o=1. Otherwise it clears sel_o and leaves addr_o unchanged.
- R5: An edge with cpu_strobe_i=1, ce_i=1 and ce2_i=0 clears sel_o and leaves addr_o unchanged.
- R6: With interleave_i=0, beat k of a burst has addr_o[1:0] = (start[1:0] + k) mod 4.
- R7: With interleave_i=1, beat k of a burst has addr_o[1:0] = start[1:0] XOR k.
- R8: An edge with no accepted strobe and adv_i=0 leaves addr_o unchanged.
- R9: An accepted strobe wins over adv_i: the new address appears at beat 0 even when adv_i=1.
- R10: During a burst, addr_o[ADDR_W-1:2] stays fixed. After four advances the low bits are back at the start offset.
- R11: While sel_o=0, adv_i has no effect on addr_o.
- R12: interleave_i is sampled on the clock edge. A change of mode in the middle of a burst changes addr_o[1:0] one edge later, with the beat count kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External address |
| cpu_strobe_i | input | 1 | Processor burst-start strobe, active high |
| ctl_strobe_i | input | 1 | Controller burst-start strobe, active high |
| adv_i | input | 1 | Advance the burst by one beat |
| ce_i | input | 1 | Primary chip enable, active high |
| ce2_i | input | 1 | Secondary chip enable, active high |
| interleave_i | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_o | output | ADDR_W | Current internal address |
| sel_o | output | 1 | Access selected flag |

## Verification
A fault in the stored base address shows on addr_o one edge after the load. It also stays there for the whole burst, because the upper bits never move afterwards. A fault in the beat counter or in the order logic shows as a wrong low-bit pair on the first advance. In the worst case it shows at the fourth advance, where the low bits must be back at the start offset. A wrong select state shows on sel_o right after the edge, and it also shows indirectly later: a deselected generator must then ignore advance pulses.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_STEP  = 2'd2,
    ACT_DESEL = 2'd3
  } burst_act_e;
endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
  import burst_pkg::*;
(
  input  logic       cpu_strobe_i,
  input  logic       ctl_strobe_i,
  input  logic       adv_i,
  input  logic       ce_i,
  input  logic       ce2_i,
  input  logic       sel_i,
  output burst_act_e act_o
);
  logic cpu_hit;
  logic enabled;

  assign cpu_hit = cpu_strobe_i & ce_i;  // primary enable gates the processor strobe
  assign enabled = ce_i & ce2_i;

  always_comb begin
    if (cpu_hit)            act_o = ce2_i ? ACT_LOAD : ACT_DESEL;
    else if (ctl_strobe_i)  act_o = enabled ? ACT_LOAD : ACT_DESEL;
    else if (adv_i && sel_i) act_o = ACT_STEP;
    else                    act_o = ACT_HOLD;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BURST_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               step_i,
  output logic [BURST_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (step_i) cnt_o <= cnt_o + 1'b1;  // natural wrap
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
  parameter int BURST_W = 2
) (
  input  logic [BURST_W-1:0] start_i,
  input  logic [BURST_W-1:0] cnt_i,
  input  logic               interleave_i,
  output logic [BURST_W-1:0] lo_o
);
  logic [BURST_W-1:0] lin;
  logic [BURST_W-1:0] ilv;

  assign lin = start_i + cnt_i;

  for (genvar b = 0; b < BURST_W; b++) begin : g_ilv
    assign ilv[b] = start_i[b] ^ cnt_i[b];
  end

  assign lo_o = interleave_i ? ilv : lin;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cpu_strobe_i,
  input  logic              ctl_strobe_i,
  input  logic              adv_i,
  input  logic              ce_i,
  input  logic              ce2_i,
  input  logic              interleave_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sel_o
);
  localparam int HI_W = ADDR_W - BURST_W;

  burst_act_e         act;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] lo;
  logic               sel_q;
  logic               mode_q;

  burst_cmd_decode u_dec (
    .cpu_strobe_i (cpu_strobe_i),
    .ctl_strobe_i (ctl_strobe_i),
    .adv_i        (adv_i),
    .ce_i         (ce_i),
    .ce2_i        (ce2_i),
    .sel_i        (sel_q),
    .act_o        (act)
  );

  burst_beat_ctr #(.BURST_W(BURST_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (act == ACT_LOAD),
    .step_i (act == ACT_STEP),
    .cnt_o  (cnt_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      sel_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= interleave_i;
      unique case (act)
        ACT_LOAD: begin
          base_q <= addr_i;
          sel_q  <= 1'b1;
        end
        ACT_DESEL: sel_q <= 1'b0;
        default: ;
      endcase
    end
  end

  burst_order_map #(.BURST_W(BURST_W)) u_map (
    .start_i      (base_q[BURST_W-1:0]),
    .cnt_i        (cnt_q),
    .interleave_i (mode_q),
    .lo_o         (lo)
  );

  assign addr_o = {base_q[ADDR_W-1 -: HI_W], lo};
  assign sel_o  = sel_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W  = 18,
  parameter int BURST_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              cpu_strobe_i,
  input logic              ctl_strobe_i,
  input logic              adv_i,
  input logic              ce_i,
  input logic              ce2_i,
  input logic              interleave_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              sel_o
);
  logic any_load;
  assign any_load = (cpu_strobe_i & ce_i) | ctl_strobe_i;

  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_state: assert (addr_o == '0 && !sel_o);
    end
  end

  a_r2_cpu_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_strobe_i && ce_i && ce2_i) |=> (sel_o && addr_o == $past(addr_i)));

  a_r3_cpu_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_strobe_i && !ce_i && !ctl_strobe_i && !adv_i) |=>
      ($stable(sel_o) && $stable(addr_o[ADDR_W-1:BURST_W])));

  a_r4_ctl_desel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_strobe_i && !(cpu_strobe_i && ce_i) && !(ce_i && ce2_i)) |=> !sel_o);

  a_r5_cpu_desel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_strobe_i && ce_i && !ce2_i) |=> (!sel_o && $stable(addr_o[ADDR_W-1:BURST_W])));

  a_r10_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_load |=> $stable(addr_o[ADDR_W-1:BURST_W]));

  a_r11_no_step_desel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_o && !any_load && interleave_i == $past(interleave_i)) |=> $stable(addr_o));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .cpu_strobe_i (cpu_strobe_i),
  .ctl_strobe_i (ctl_strobe_i),
  .adv_i        (adv_i),
  .ce_i         (ce_i),
  .ce2_i        (ce2_i),
  .interleave_i (interleave_i),
  .addr_o       (addr_o),
  .sel_o        (sel_o)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int ADDR_W = 18;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic              sel;
    string             req;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              cpu_strobe_i = 1'b0, ctl_strobe_i = 1'b0, adv_i = 1'b0;
  logic              ce_i = 1'b0, ce2_i = 1'b0, interleave_i = 1'b0;
  logic [ADDR_W-1:0] addr_o;
  logic              sel_o;

  int n_chk = 0, n_fail = 0;
  exp_t sb[$];

  // reference state
  logic [ADDR_W-1:0] m_base = '0;
  int                m_cnt = 0;
  logic              m_sel = 1'b0;
  logic              m_mode = 1'b0;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i),
    .cpu_strobe_i(cpu_strobe_i), .ctl_strobe_i(ctl_strobe_i), .adv_i(adv_i),
    .ce_i(ce_i), .ce2_i(ce2_i), .interleave_i(interleave_i),
    .addr_o(addr_o), .sel_o(sel_o)
  );

  function automatic logic [ADDR_W-1:0] m_addr();
    int lo;
    lo = m_mode ? (int'(m_base[1:0]) ^ m_cnt) : ((int'(m_base[1:0]) + m_cnt) % 4);
    return {m_base[ADDR_W-1:2], 2'(lo)};
  endfunction

  task automatic check(string req, logic [ADDR_W-1:0] a, logic s,
                       logic [ADDR_W-1:0] ea, logic es);
    n_chk++;
    if (a !== ea || s !== es) begin
      n_fail++;
      $display("FAIL %s: addr_o=%h sel_o=%b expected addr_o=%h sel_o=%b", req, a, s, ea, es);
    end
  endtask

  task automatic drive(string req, logic cpu, logic ctl, logic adv, logic e1, logic e2,
                       logic il, logic [ADDR_W-1:0] a);
    exp_t e;
    @(negedge clk);
    cpu_strobe_i = cpu; ctl_strobe_i = ctl; adv_i = adv;
    ce_i = e1; ce2_i = e2; interleave_i = il; addr_i = a;
    if (cpu && e1) begin
      if (e2) begin m_base = a; m_cnt = 0; m_sel = 1'b1; end
      else m_sel = 1'b0;
    end else if (ctl) begin
      if (e1 && e2) begin m_base = a; m_cnt = 0; m_sel = 1'b1; end
      else m_sel = 1'b0;
    end else if (adv && m_sel) begin
      m_cnt = (m_cnt + 1) % 4;
    end
    m_mode = il;
    e.addr = m_addr(); e.sel = m_sel; e.req = req;
    sb.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, addr_o, sel_o, e.addr, e.sel);
      end
    end
  end

  // watchdog
  initial begin
    #2000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: addr_o=%h sel_o=%b expected run to complete", addr_o, sel_o);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1;
    check("R1", addr_o, sel_o, '0, 1'b0);
    repeat (3) @(negedge clk);
    check("R1", addr_o, sel_o, '0, 1'b0);
    rst_ni = 1'b1;

    // R2 + R6 + R10: processor load, linear advance through wrap
    drive("R2", 1, 0, 0, 1, 1, 0, 18'h12345);
    drive("R6", 0, 0, 1, 1, 1, 0, '0);
    drive("R6", 0, 0, 1, 1, 1, 0, '0);
    drive("R6", 0, 0, 1, 1, 1, 0, '0);
    drive("R10", 0, 0, 1, 1, 1, 0, '0);
    // R8: hold
    drive("R8", 0, 0, 0, 1, 1, 0, 18'h3FFFF);
    drive("R8", 0, 0, 0, 0, 0, 0, 18'h00000);
    // R9: strobe beats advance
    drive("R6", 0, 0, 1, 1, 1, 0, '0);
    drive("R9", 1, 0, 1, 1, 1, 0, 18'h2ABC6);
    drive("R6", 0, 0, 1, 1, 1, 0, '0);
    drive("R6", 0, 0, 1, 1, 1, 0, '0);
    // R4 + R7: controller load, interleaved order from offset 3
    drive("R4", 0, 1, 0, 1, 1, 1, 18'h0F0F3);
    drive("R7", 0, 0, 1, 1, 1, 1, '0);
    drive("R7", 0, 0, 1, 1, 1, 1, '0);
    drive("R7", 0, 0, 1, 1, 1, 1, '0);
    drive("R10", 0, 0, 1, 1, 1, 1, '0);
    // R12: switch order mid-burst
    drive("R7", 0, 0, 1, 1, 1, 1, '0);
    drive("R12", 0, 0, 0, 1, 1, 0, '0);
    drive("R12", 0, 0, 1, 1, 1, 0, '0);
    // R3: processor strobe with primary enable low
    drive("R3", 1, 0, 0, 0, 1, 0, 18'h11111);
    drive("R3", 1, 0, 0, 0, 0, 0, 18'h22222);
    // R5: accepted processor strobe, secondary enable low
    drive("R5", 1, 0, 0, 1, 0, 0, 18'h33333);
    // R11: advance while deselected
    drive("R11", 0, 0, 1, 1, 1, 0, '0);
    drive("R11", 0, 0, 1, 1, 1, 0, '0);
    // R4: controller strobe load, then deselect paths
    drive("R4", 0, 1, 1, 1, 1, 0, 18'h05554);
    drive("R4", 0, 1, 0, 1, 0, 0, 18'h3AAAA);
    drive("R4", 0, 1, 0, 0, 1, 0, 18'h3AAAA);
    drive("R11", 0, 0, 1, 1, 1, 0, '0);
    drive("R2", 1, 1, 0, 1, 1, 1, 18'h3FFFE);
    drive("R7", 0, 0, 1, 1, 1, 1, '0);
    drive("R8", 0, 0, 0, 1, 1, 1, '0);

    @(negedge clk);
    cpu_strobe_i = 0; ctl_strobe_i = 0; adv_i = 0;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule